// File: doc/BRIEF.md
# Flash Toggle-Bit Status Generator

This block models, on the device side, the write-status bits of a parallel NOR flash. While an embedded program or erase runs, a read does not return array data. It returns three status bits instead. The first is a device-wide toggle bit that inverts on every completed read while the device is actively busy. The second is a sector-local toggle bit that inverts only when the read address falls in a sector marked for erase. The third is a timeout flag that reports an exhausted internal pulse count. The block also drives an array-data select that tells the output multiplexer whether to present cell data or status.

The command decoder drives the block with a command-start pulse at the rising edge of the final write of each sequence, together with the operation kind and whether its target is protected. The decoder also supplies the live busy and suspend flags, the erase sector mask and a reset-command pulse. A command aimed at protected storage changes no cells. It makes the device look busy for a fixed window, counted in clock cycles, and then the device returns to array reads.

Top module: `flash_toggle_status`

## Requirements
- R1: While reset is held and just after it, dq6, dq2 and dq5 read 0 and array_sel reads 1.
- R2: While prog_busy is 1, or erase_busy is 1 with erase_susp 0, or a protected-command window is open, dq6 inverts once for each read, one cycle after rd_strobe falls, whatever the address.
- R3: With erase_susp 1, prog_busy 0 and no window open, reads leave dq6 unchanged. A program run during suspend (prog_busy 1) makes dq6 invert again.
- R4: While erase_busy is 1 (suspended or not), dq2 inverts on a read whose sector index is selected in sect_sel, and holds otherwise. The sector index is the top SECT_W bits of rd_addr, and bit i of sect_sel selects sector i. The address is captured while rd_strobe is high.
- R5: cmd_go with cmd_erase 1 and cmd_prot 1 opens a window of ERASE_WIN_CYC cycles, starting the cycle after cmd_go. During the window dq6 toggles and array_sel is 0. After it, array_sel returns to 1.
- R6: cmd_go with cmd_erase 0 and cmd_prot 1 opens a window of PROG_WIN_CYC cycles, with the same behaviour as R5.
- R7: pulse_ovf while prog_busy or erase_busy is 1 sets dq5 on the next cycle. dq5 stays set until rst_cmd or cmd_go.
- R8: array_sel is 0 while R2's busy condition holds, while dq5 is 1, or during a suspended erase when the read address lies in a selected sector. Otherwise it is 1.
- R9: cmd_go clears dq6 and dq2 to 0 on the next cycle. It wins over a read that ends in the same cycle.
- R10: rst_cmd clears dq5 and closes any open protected window on the next cycle. It wins over a simultaneous cmd_go or pulse_ovf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_strobe | input | 1 | Read cycle active (chip or output enable) |
| rd_addr | input | ADDR_W | Read address |
| sect_sel | input | 2**SECT_W | Sectors selected for erase |
| cmd_go | input | 1 | Final write pulse of a command sequence |
| cmd_erase | input | 1 | Command kind: 1 erase, 0 program |
| cmd_prot | input | 1 | Command target fully protected |
| prog_busy | input | 1 | Embedded program running |
| erase_busy | input | 1 | Erase in progress or suspended |
| erase_susp | input | 1 | Erase suspended |
| pulse_ovf | input | 1 | Internal pulse count exceeded |
| rst_cmd | input | 1 | Reset command written |
| dq6 | output | 1 | Device-wide toggle bit |
| dq2 | output | 1 | Sector-local toggle bit |
| dq5 | output | 1 | Timing-limit exceeded flag |
| array_sel | output | 1 | 1: drive array data, 0: drive status |

## Verification
The hardest state to reach is a program running inside an erase suspend. There the device-wide toggle must resume while the sector-local toggle keeps following the erase mask, and array_sel must still depend on the address. The stimulus builds this step by step: it starts an erase, reads selected and unselected sectors, raises suspend, then raises program busy. The sector-index latch and the toggle flops therefore carry history from every earlier phase. A read that ends in the same cycle as cmd_go, and a rst_cmd issued inside a protected window, are placed on exact cycles to exercise the priority rules.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
   function automatic int unsigned win_bits(input int unsigned a, input int unsigned b);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m < 2) ? 1 : $clog2(m + 1);
   endfunction
endpackage

// File: rtl/tbs_sector_hit.sv
module tbs_sector_hit #(
   parameter int SECT_W = 3,
   localparam int NSECT = 1 << SECT_W
) (
   input  logic [SECT_W-1:0] idx,
   input  logic [NSECT-1:0]  sel,
   output logic              hit
);
   logic [NSECT-1:0] match;
   for (genvar s = 0; s < NSECT; s++) begin : g_sect
      assign match[s] = sel[s] && (idx == SECT_W'(s));
   end
   assign hit = |match;
endmodule

// File: rtl/tbs_window_timer.sv
module tbs_window_timer import tbs_pkg::*; #(
   parameter int unsigned PROG_WIN_CYC  = 100,
   parameter int unsigned ERASE_WIN_CYC = 5000,
   localparam int unsigned CW = win_bits(PROG_WIN_CYC, ERASE_WIN_CYC)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic load,
   input  logic is_erase,
   output logic busy
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (clr)          cnt <= '0;
      else if (load)         cnt <= is_erase ? CW'(ERASE_WIN_CYC) : CW'(PROG_WIN_CYC);
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/tbs_toggle_bit.sv
module tbs_toggle_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 1'b0;
      else if (clr)   q <= 1'b0;
      else if (adv)   q <= ~q;
   end
endmodule

// File: rtl/flash_toggle_status.sv
module flash_toggle_status #(
   parameter int ADDR_W = 19,
   parameter int SECT_W = 3,
   parameter int unsigned PROG_WIN_CYC  = 100,
   parameter int unsigned ERASE_WIN_CYC = 5000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rd_strobe,
   input  logic [ADDR_W-1:0]        rd_addr,
   input  logic [(1<<SECT_W)-1:0]   sect_sel,
   input  logic                     cmd_go,
   input  logic                     cmd_erase,
   input  logic                     cmd_prot,
   input  logic                     prog_busy,
   input  logic                     erase_busy,
   input  logic                     erase_susp,
   input  logic                     pulse_ovf,
   input  logic                     rst_cmd,
   output logic                     dq6,
   output logic                     dq2,
   output logic                     dq5,
   output logic                     array_sel
);
   localparam int IDX_LSB = ADDR_W - SECT_W;

   if (SECT_W < 1 || SECT_W >= ADDR_W) begin : g_bad_sect
      $error("SECT_W must lie in 1..ADDR_W-1");
   end
   if (PROG_WIN_CYC < 1 || ERASE_WIN_CYC < 1) begin : g_bad_win
      $error("protected windows need at least one cycle");
   end

   logic              rd_q;
   logic [SECT_W-1:0] idx_q;
   logic              rd_done;
   logic              fake_busy;
   logic              dev_busy;
   logic              hit_now;
   logic              hit_rd;
   logic              dq5_q;
   logic [1:0]        tgl_adv;
   logic [1:0]        tgl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= 1'b0;
         idx_q <= '0;
      end else begin
         rd_q <= rd_strobe;
         if (rd_strobe) idx_q <= rd_addr[ADDR_W-1:IDX_LSB];
      end
   end

   assign rd_done = rd_q && !rd_strobe;

   tbs_window_timer #(
      .PROG_WIN_CYC (PROG_WIN_CYC),
      .ERASE_WIN_CYC(ERASE_WIN_CYC)
   ) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (rst_cmd),
      .load    (cmd_go && cmd_prot),
      .is_erase(cmd_erase),
      .busy    (fake_busy)
   );

   tbs_sector_hit #(.SECT_W(SECT_W)) u_hit_now (
      .idx(rd_addr[ADDR_W-1:IDX_LSB]),
      .sel(sect_sel),
      .hit(hit_now)
   );

   tbs_sector_hit #(.SECT_W(SECT_W)) u_hit_rd (
      .idx(idx_q),
      .sel(sect_sel),
      .hit(hit_rd)
   );

   assign dev_busy   = prog_busy || (erase_busy && !erase_susp) || fake_busy;
   assign tgl_adv[0] = rd_done && dev_busy;
   assign tgl_adv[1] = rd_done && erase_busy && hit_rd;

   for (genvar t = 0; t < 2; t++) begin : g_tgl
      tbs_toggle_bit u_tb (
         .clk  (clk),
         .rst_n(rst_n),
         .clr  (cmd_go),
         .adv  (tgl_adv[t]),
         .q    (tgl_q[t])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      dq5_q <= 1'b0;
      else if (rst_cmd || cmd_go)                      dq5_q <= 1'b0;
      else if (pulse_ovf && (prog_busy || erase_busy)) dq5_q <= 1'b1;
   end

   assign dq6       = tgl_q[0];
   assign dq2       = tgl_q[1];
   assign dq5       = dq5_q;
   assign array_sel = !(dev_busy || dq5_q || (erase_busy && (!erase_susp || hit_now)));
endmodule

// File: rtl/tbs_chk.sv
module tbs_chk (
   input logic clk,
   input logic rst_n,
   input logic rd_strobe,
   input logic cmd_go,
   input logic rst_cmd,
   input logic erase_busy,
   input logic dev_busy,
   input logic dq6,
   input logic dq2,
   input logic dq5,
   input logic array_sel
);
   logic rd_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_seen <= 1'b0;
      else        rd_seen <= rd_strobe;
   end

   // R2
   tgl6_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_seen && !rd_strobe && !cmd_go && dev_busy) |=> (dq6 != $past(dq6)));
   // R3
   tgl6_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_go && !(rd_seen && !rd_strobe)) |=> $stable(dq6));
   // R4
   tgl2_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_go && !erase_busy) |=> $stable(dq2));
   // R9
   tgl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_go |=> (!dq6 && !dq2));
   // R10
   dq5_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_cmd |=> !dq5);
   // R8
   status_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dq5 || dev_busy) |-> !array_sel);
endmodule

bind flash_toggle_status tbs_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_strobe (rd_strobe),
   .cmd_go    (cmd_go),
   .rst_cmd   (rst_cmd),
   .erase_busy(erase_busy),
   .dev_busy  (dev_busy),
   .dq6       (dq6),
   .dq2       (dq2),
   .dq5       (dq5),
   .array_sel (array_sel)
);

// File: tb/tb_flash_toggle_status.sv
module tb_flash_toggle_status;
   localparam int AW = 12;
   localparam int SW = 3;
   localparam int PW = 10;
   localparam int EW = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rd_strobe = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0] sect_sel = '0;
   logic cmd_go = 1'b0, cmd_erase = 1'b0, cmd_prot = 1'b0;
   logic prog_busy = 1'b0, erase_busy = 1'b0, erase_susp = 1'b0;
   logic pulse_ovf = 1'b0, rst_cmd = 1'b0;
   logic dq6, dq2, dq5, array_sel;

   always #4 clk = ~clk;

   flash_toggle_status #(.ADDR_W(AW), .SECT_W(SW), .PROG_WIN_CYC(PW), .ERASE_WIN_CYC(EW)) dut (
      .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_addr(rd_addr), .sect_sel(sect_sel),
      .cmd_go(cmd_go), .cmd_erase(cmd_erase), .cmd_prot(cmd_prot), .prog_busy(prog_busy),
      .erase_busy(erase_busy), .erase_susp(erase_susp), .pulse_ovf(pulse_ovf), .rst_cmd(rst_cmd),
      .dq6(dq6), .dq2(dq2), .dq5(dq5), .array_sel(array_sel));

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   string phase = "R1";

   // reference model state
   bit m6, m2, m5, m_rd;
   int m_cnt, m_idx;

   function automatic bit sel_of(int idx);
      return sect_sel[idx];
   endfunction

   function automatic bit exp_array();
      bit busy6;
      busy6 = prog_busy || (erase_busy && !erase_susp) || (m_cnt != 0);
      return !(busy6 || m5 || (erase_busy && (!erase_susp || sel_of(int'(rd_addr) >> (AW-SW)))));
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m6 = 0; m2 = 0; m5 = 0; m_rd = 0; m_cnt = 0; m_idx = 0;
      end else begin
         bit busy6, fall;
         busy6 = prog_busy || (erase_busy && !erase_susp) || (m_cnt != 0);
         fall = m_rd && !rd_strobe;
         if (cmd_go) begin m6 = 0; m2 = 0; end
         else if (fall) begin
            if (busy6) m6 = !m6;
            if (erase_busy && sel_of(m_idx)) m2 = !m2;
         end
         if (rst_cmd || cmd_go) m5 = 0;
         else if (pulse_ovf && (prog_busy || erase_busy)) m5 = 1;
         if (rst_cmd) m_cnt = 0;
         else if (cmd_go && cmd_prot) m_cnt = cmd_erase ? EW : PW;
         else if (m_cnt != 0) m_cnt = m_cnt - 1;
         m_rd = rd_strobe;
         if (rd_strobe) m_idx = int'(rd_addr) >> (AW-SW);
      end
   end

   task automatic check(input bit act, input bit exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", phase, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         check(dq6, m6, "dq6");
         check(dq2, m2, "dq2");
         check(dq5, m5, "dq5");
         check(array_sel, exp_array(), "array_sel");
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
   endtask

   task automatic rd(input int sect);
      @(posedge clk); #2;
      rd_strobe = 1'b1; rd_addr = AW'((sect << (AW-SW)) | 5);
      @(posedge clk); #2;
      rd_strobe = 1'b0;
      step(1);
   endtask

   task automatic go(input bit er, input bit pr);
      @(posedge clk); #2;
      cmd_go = 1'b1; cmd_erase = er; cmd_prot = pr;
      @(posedge clk); #2;
      cmd_go = 1'b0; cmd_prot = 1'b0;
   endtask

   // direct hand-computed checks, sampled mid-cycle
   task automatic expect_now(input bit act, input bit exp, input string what);
      #2; check(act, exp, what);
   endtask

   initial begin
      step(3);
      phase = "R1";
      expect_now(dq6, 0, "dq6 reset"); expect_now(array_sel, 1, "array reset");
      rst_n = 1'b1;
      step(2);

      phase = "R2";
      go(0, 0); prog_busy = 1'b1;
      rd(0); rd(3); rd(7);
      expect_now(dq6, 1, "dq6 after three reads");
      expect_now(array_sel, 0, "status while programming");
      prog_busy = 1'b0; rd(1);
      expect_now(dq6, 1, "dq6 frozen when idle");

      phase = "R4";
      go(1, 0); sect_sel = 8'b0010_0100; erase_busy = 1'b1;
      rd(2); rd(5); rd(0); rd(6);
      expect_now(dq2, 0, "dq2 two selected reads");
      rd(2);
      expect_now(dq2, 1, "dq2 third selected read");

      phase = "R3";
      erase_susp = 1'b1; step(1);
      rd(0); rd(2); rd(4);
      rd_addr = AW'(2 << (AW-SW)); step(1);
      phase = "R8";
      expect_now(array_sel, 0, "suspended selected sector");
      rd_addr = AW'(1 << (AW-SW)); step(1);
      expect_now(array_sel, 1, "suspended unselected sector");
      phase = "R3";
      prog_busy = 1'b1; rd(1); rd(5);
      prog_busy = 1'b0; erase_susp = 1'b0;

      phase = "R7";
      @(posedge clk); #2; pulse_ovf = 1'b1; @(posedge clk); #2; pulse_ovf = 1'b0;
      erase_busy = 1'b0; step(2);
      expect_now(dq5, 1, "dq5 sticky");
      phase = "R10";
      @(posedge clk); #2; rst_cmd = 1'b1; @(posedge clk); #2; rst_cmd = 1'b0;
      expect_now(array_sel, 1, "array after reset command");

      phase = "R5";
      go(1, 1);
      for (int k = 0; k < 12; k++) rd(k % 8);
      step(EW);
      expect_now(array_sel, 1, "erase window closed");

      phase = "R6";
      go(0, 1); rd(4); rd(4);
      step(PW);
      expect_now(array_sel, 1, "program window closed");

      phase = "R10";
      go(0, 1); rd(3); step(2);
      @(posedge clk); #2; rst_cmd = 1'b1; cmd_go = 1'b1; cmd_prot = 1'b1;
      @(posedge clk); #2; rst_cmd = 1'b0; cmd_go = 1'b0; cmd_prot = 1'b0;
      expect_now(array_sel, 1, "window closed by reset command");

      phase = "R9";
      prog_busy = 1'b1; rd(2);
      @(posedge clk); #2; rd_strobe = 1'b1; rd_addr = '0;
      @(posedge clk); #2; rd_strobe = 1'b0; cmd_go = 1'b1;
      @(posedge clk); #2; cmd_go = 1'b0;
      expect_now(dq6, 0, "cmd_go beats read end");
      prog_busy = 1'b0;
      step(4);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule